// File: doc/BRIEF.md
# NVM Read Prefetch Line Buffer

This block serves read transfers from an AHB-Lite slave port out of a slow non-volatile array that returns 64 bits per access. A small line store holds four consecutive 64-bit words of one 32-byte line. The 32-bit word chosen by the bus address comes straight out of that store when it is present. When it is not, the bus is stalled while the array is read. Every array read lasts a number of cycles set by a 2-bit frequency-range input, so slower array timing can be met at a faster bus clock.

A single read that misses fetches only its own 64-bit entry. An 8-beat wrapping burst that misses fetches every missing entry of the line. The fill starts with the entry of the first beat and moves upward modulo four. Each entry has its own valid bit, so a beat completes as soon as its entry has arrived. A write to the array region or a pulse on the flush input drops every entry and abandons any fill in progress. After that, no stale word can be returned.

Top module: `nvm_prefetch_buf`

## Requirements
- R1: After synchronous reset, hreadyout is 1, nvm_req is 0 and no entry is valid, so the first read always goes to the array.
- R2: A read whose line tag (haddr[ADDR_W-1:5]) matches the stored tag and whose entry is valid completes in its first data-phase cycle without any array read.
- R3: A single read that misses launches exactly one array read, of the 64-bit word at byte address bits [ADDR_W-1:3]. Its data phase stalls freq_sel+2 cycles.
- R4: Every array read holds nvm_req high and nvm_addr steady for freq_sel+1 cycles, and the returned word is taken in the last of them, for every freq_sel value 0 to 3.
- R5: haddr[4:3] selects the 64-bit entry. haddr[2]=1 returns bits [63:32] of that entry and haddr[2]=0 returns bits [31:0].
- R6: A read with hburst=3'b100 (8-beat wrap) that misses fetches all invalid entries of its line: four reads for a line not held. The first read is of the first beat's entry, the rest follow ascending modulo 4, and all eight beats return correct data.
- R7: The first beat of a wrapping burst on a line not held completes after freq_sel+2 stall cycles, without waiting for the rest of the line.
- R8: A miss to a different line tag discards every entry of the line held before, so returning to the old line costs an array read again.
- R9: An accepted write (hwrite=1 with htrans NONSEQ 2'b10 or SEQ 2'b11) clears every valid bit and stops any fill in progress. Its data phase completes with no wait state.
- R10: A one-cycle pulse on flush clears every valid bit and stops any fill in progress.
- R11: Bursts other than the 8-beat wrap are served beat by beat. Each miss fetches only its own entry, so a 4-beat incrementing read spanning two entries costs two array reads.
- R12: freq_sel is sampled once at the start of each array read. Changing it while that read is in progress does not change that read's length or its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type (2'b10 NONSEQ, 2'b11 SEQ, others no transfer) |
| hwrite | input | 1 | Write transfer |
| hburst | input | 3 | Burst type (3'b100 is the 8-beat wrap) |
| haddr | input | ADDR_W-2 | Word address, byte address bits [ADDR_W-1:2] |
| hreadyout | output | 1 | Low while a read data phase waits for its word |
| hrdata | output | 32 | Read data |
| freq_sel | input | 2 | Extra array access cycles per read (read lasts freq_sel+1 cycles) |
| flush | input | 1 | Drop all held entries |
| nvm_req | output | 1 | Array read in progress |
| nvm_addr | output | ADDR_W-3 | 64-bit word address of the array read |
| nvm_rdata | input | 64 | Array read data, already corrected |

## Verification
The bench's array model returns a garbage pattern until a read has been held for its full wait count. A design that cut the wait short, or that re-read freq_sel partway through a read, would therefore return wrong words. The bench also checks the exact stall count of a cold single read for every freq_sel value. It logs the entry order of a cold wrapping fill and times the first beat of that burst. A fill that ran in the wrong order, or a buffer that held the first beat back until the whole line had arrived, would show up there. After a write, after a flush and after a move to another line, the bench counts array reads and checks data against a changed array image. A design that kept a valid bit across any of these would skip the array access or return old data.

// File: rtl/npb_pkg.sv
package npb_pkg;
    localparam int ENTRIES  = 4;
    localparam int ENT_W    = $clog2(ENTRIES);
    localparam int DW       = 64;
    localparam int HW       = 32;
    localparam int FRQ_W    = 2;
    localparam int WORD_LSB = $clog2(DW / 8);
    localparam int LINE_LSB = $clog2(ENTRIES * DW / 8);

    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;
    localparam logic [2:0] HB_WRAP8  = 3'b100;

    typedef logic [ENTRIES-1:0] emask_t;
    typedef logic [ENT_W-1:0]   eidx_t;

    // data-phase context of an accepted bus transfer
    typedef struct packed {
        logic  rd;
        logic  wrap;
        eidx_t ent;
        logic  half;
    } dph_t;

    // first pending entry after cur, searching upward modulo ENTRIES
    function automatic eidx_t next_pending(input emask_t p, input eidx_t cur);
        eidx_t r;
        logic  found;
        r     = cur;
        found = 1'b0;
        for (int k = 1; k < ENTRIES; k++) begin
            if (!found && p[eidx_t'(32'(cur) + k)]) begin
                r     = eidx_t'(32'(cur) + k);
                found = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/npb_line_store.sv
module npb_line_store
    import npb_pkg::*;
#(
    parameter int TAG_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             set_tag_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             we,
    input  eidx_t            we_ent,
    input  logic [DW-1:0]    we_data,
    input  logic [TAG_W-1:0] lk_tag,
    input  eidx_t            lk_ent,
    input  logic             lk_half,
    output logic             hit,
    output logic [HW-1:0]    rd32,
    output emask_t           valid_o,
    output logic [TAG_W-1:0] tag_o
);
    logic [DW-1:0] dat_w [ENTRIES];
    logic [DW-1:0] sel_w;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic          vld_q;
        logic [DW-1:0] dat_q;
        always_ff @(posedge clk) begin
            if (rst || clr_all || set_tag_en)
                vld_q <= 1'b0;
            else if (we && we_ent == eidx_t'(g))
                vld_q <= 1'b1;
            if (we && we_ent == eidx_t'(g))
                dat_q <= we_data;
        end
        assign valid_o[g] = vld_q;
        assign dat_w[g]   = dat_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tag_o <= '0;
        else if (set_tag_en)
            tag_o <= set_tag;
    end

    assign hit   = (tag_o == lk_tag) && valid_o[lk_ent];
    assign sel_w = dat_w[lk_ent];
    assign rd32  = lk_half ? sel_w[DW-1:HW] : sel_w[HW-1:0];

    // a captured array word makes its entry valid on the next cycle
    p_fill_marks_r6: assert property (@(posedge clk) disable iff (rst)
        (we && !clr_all && !set_tag_en) |=> valid_o[$past(we_ent)]);
endmodule

// File: rtl/npb_fetch_ctl.sv
module npb_fetch_ctl
    import npb_pkg::*;
#(
    parameter int TAG_W = 15
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   kill,
    input  logic                   start,
    input  logic [TAG_W-1:0]       start_tag,
    input  eidx_t                  start_ent,
    input  emask_t                 start_mask,
    input  logic [FRQ_W-1:0]       freq,
    output logic                   busy,
    output logic [TAG_W+ENT_W-1:0] arr_addr,
    output logic                   cap_en,
    output eidx_t                  cap_ent
);
    logic             busy_q;
    emask_t           pend_q;
    emask_t           pend_n;
    eidx_t            cur_q;
    logic [FRQ_W-1:0] wcnt_q;
    logic [TAG_W-1:0] tag_q;

    assign pend_n   = pend_q & ~(emask_t'(1) << cur_q);
    assign cap_en   = busy_q && (wcnt_q == '0);
    assign cap_ent  = cur_q;
    assign busy     = busy_q;
    assign arr_addr = {tag_q, cur_q};

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            busy_q <= 1'b0;
            pend_q <= '0;
            wcnt_q <= '0;
            if (rst) begin
                cur_q <= '0;
                tag_q <= '0;
            end
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            pend_q <= start_mask;
            cur_q  <= start_ent;
            tag_q  <= start_tag;
            wcnt_q <= freq;
        end else if (busy_q) begin
            if (wcnt_q != '0) begin
                wcnt_q <= wcnt_q - 1'b1;
            end else begin
                pend_q <= pend_n;
                if (pend_n == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    cur_q  <= next_pending(pend_n, cur_q);
                    wcnt_q <= freq;
                end
            end
        end
    end

    // address held for the whole access window
    p_hold_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && wcnt_q != '0 && !kill) |=> (busy && $stable(arr_addr)));
    // the entry being read is always one still owed to the line
    p_cur_pending_r6: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> pend_q[cur_q]);
endmodule

// File: rtl/nvm_prefetch_buf.sv
module nvm_prefetch_buf
    import npb_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hsel,
    input  logic [1:0]               htrans,
    input  logic                     hwrite,
    input  logic [2:0]               hburst,
    input  logic [ADDR_W-1:2]        haddr,
    output logic                     hreadyout,
    output logic [HW-1:0]            hrdata,
    input  logic [FRQ_W-1:0]         freq_sel,
    input  logic                     flush,
    output logic                     nvm_req,
    output logic [ADDR_W-WORD_LSB-1:0] nvm_addr,
    input  logic [DW-1:0]            nvm_rdata
);
    localparam int TAG_W = ADDR_W - LINE_LSB;

    dph_t             dq_q;
    logic [TAG_W-1:0] dtag_q;
    logic             xfer, accept, wr_acc, kill, launch, tag_new;
    logic             hit_w, busy_w, cap_en;
    logic [HW-1:0]    rd32_w;
    emask_t           valid_w, start_mask;
    eidx_t            cap_ent;
    logic [TAG_W-1:0] tag_w;

    assign xfer   = hsel && (htrans == HT_NONSEQ || htrans == HT_SEQ);
    assign accept = xfer && hreadyout;
    assign wr_acc = accept && hwrite;
    assign kill   = flush || wr_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_q   <= '0;
            dtag_q <= '0;
        end else if (hreadyout) begin
            dq_q.rd   <= accept && !hwrite;
            dq_q.wrap <= (hburst == HB_WRAP8);
            dq_q.ent  <= haddr[LINE_LSB-1:WORD_LSB];
            dq_q.half <= haddr[WORD_LSB-1];
            dtag_q    <= haddr[ADDR_W-1:LINE_LSB];
        end
    end

    assign tag_new = (tag_w != dtag_q);
    assign launch  = dq_q.rd && !hit_w && !busy_w && !kill;

    always_comb begin
        if (dq_q.wrap)
            start_mask = tag_new ? '1 : ~valid_w;
        else
            start_mask = emask_t'(1) << dq_q.ent;
    end

    npb_line_store #(.TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr_all    (kill),
        .set_tag_en (launch && tag_new),
        .set_tag    (dtag_q),
        .we         (cap_en && !kill),
        .we_ent     (cap_ent),
        .we_data    (nvm_rdata),
        .lk_tag     (dtag_q),
        .lk_ent     (dq_q.ent),
        .lk_half    (dq_q.half),
        .hit        (hit_w),
        .rd32       (rd32_w),
        .valid_o    (valid_w),
        .tag_o      (tag_w)
    );

    npb_fetch_ctl #(.TAG_W(TAG_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .kill       (kill),
        .start      (launch),
        .start_tag  (dtag_q),
        .start_ent  (dq_q.ent),
        .start_mask (start_mask),
        .freq       (freq_sel),
        .busy       (busy_w),
        .arr_addr   (nvm_addr),
        .cap_en     (cap_en),
        .cap_ent    (cap_ent)
    );

    assign hreadyout = !(dq_q.rd && !hit_w);
    assign hrdata    = (dq_q.rd && hit_w) ? rd32_w : '0;
    assign nvm_req   = busy_w;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (hreadyout && !nvm_req));
    // a stalled read with the array idle starts an access next cycle
    p_stall_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (!hreadyout && !nvm_req && !flush) |=> nvm_req);
    p_write_abort_r9: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> !nvm_req);
    p_flush_abort_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> !nvm_req);
endmodule

// File: tb/test_nvm_prefetch_buf.sv
`timescale 1ns/1ps
module test_nvm_prefetch_buf;
    localparam int AW = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsel = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hburst = 3'b000;
    logic [AW-1:2] haddr = '0;
    logic        hreadyout;
    logic [31:0] hrdata;
    logic [1:0]  fsel = 2'd2;
    logic        flush = 1'b0;
    logic        nvm_req;
    logic [AW-4:0] nvm_addr;
    logic [63:0] nvm_rdata;

    int nchk = 0, nfail = 0, gen = 0, nread = 0;
    logic [AW-4:0] rlog [16];

    always #4 clk = ~clk;

    nvm_prefetch_buf #(.ADDR_W(AW)) i_nvm_prefetch_buf (
        .clk(clk), .rst(rst), .hsel(hsel), .htrans(htrans), .hwrite(hwrite),
        .hburst(hburst), .haddr(haddr), .hreadyout(hreadyout), .hrdata(hrdata),
        .freq_sel(fsel), .flush(flush), .nvm_req(nvm_req), .nvm_addr(nvm_addr),
        .nvm_rdata(nvm_rdata)
    );

    function automatic logic [63:0] mem64(input logic [AW-4:0] wa, input int g);
        logic [31:0] x;
        x = 32'(wa);
        return {(x * 32'h9E3779B1) ^ (32'(g) * 32'h01000193), ~(x * 32'h85EBCA6B) + 32'(g)};
    endfunction

    function automatic logic [31:0] exp_word(input logic [AW-1:0] a, input int g);
        logic [63:0] w;
        w = mem64(a[AW-1:3], g);
        return a[2] ? w[63:32] : w[31:0];
    endfunction

    // array model: data valid only after the read was held freq+1 cycles
    logic          last_req = 1'b0;
    logic [AW-4:0] last_addr = '0;
    int            age = 0, need_q = 1, cur_age, cur_need;
    logic          new_rd;
    assign new_rd = nvm_req && !(last_req && nvm_addr == last_addr);
    always_comb begin
        cur_age   = new_rd ? 1 : age + 1;
        cur_need  = new_rd ? int'(fsel) + 1 : need_q;
        nvm_rdata = (cur_age >= cur_need) ? mem64(nvm_addr, gen) : 64'hDEAD_BEEF_DEAD_BEEF;
    end
    always @(posedge clk) begin
        if (new_rd) begin
            need_q <= int'(fsel) + 1;
            rlog[nread % 16] <= nvm_addr;
            nread <= nread + 1;
        end
        age       <= new_rd ? 1 : age + 1;
        last_req  <= nvm_req;
        last_addr <= nvm_addr;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int i, input logic [2:0] hb);
        if (hb == 3'b100)
            return {a[AW-1:5], 5'(a[4:0] + 5'(4 * i))};
        return a + AW'(4 * i);
    endfunction

    task automatic rd_burst(input logic [AW-1:0] a, input int beats, input logic [2:0] hb,
                            input int chg_at, input logic [1:0] chg_f, input string req,
                            output int st0);
        logic [AW-1:0] ba;
        int st;
        st0 = 0;
        @(negedge clk);
        hsel = 1'b1; hwrite = 1'b0; hburst = hb; htrans = 2'b10;
        haddr = a[AW-1:2];
        @(posedge clk);
        for (int i = 0; i < beats; i++) begin
            ba = beat_addr(a, i, hb);
            @(negedge clk);
            if (i + 1 < beats) begin
                htrans = 2'b11;
                haddr  = beat_addr(a, i + 1, hb) >> 2;
            end else begin
                htrans = 2'b00;
                hsel   = 1'b0;
            end
            st = 0;
            while (hreadyout !== 1'b1) begin
                if (st == chg_at) fsel = chg_f;
                st++;
                @(negedge clk);
            end
            if (i == 0) st0 = st;
            chk(req, 64'(hrdata), 64'(exp_word(ba, gen)));
            @(posedge clk);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a);
        @(negedge clk);
        hsel = 1'b1; hwrite = 1'b1; htrans = 2'b10; hburst = 3'b000;
        haddr = a[AW-1:2];
        @(posedge clk);
        @(negedge clk);
        hsel = 1'b0; hwrite = 1'b0; htrans = 2'b00;
        gen++;
        chk("R9 write data phase ready", 64'(hreadyout), 64'd1);
        @(posedge clk);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        int st, n0, seed;
        seed = int'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 hreadyout after reset", 64'(hreadyout), 64'd1);
        chk("R1 nvm_req after reset", 64'(nvm_req), 64'd0);
        @(posedge clk);

        // R3 / R1: cold single read
        fsel = 2'd2; n0 = nread;
        rd_burst(20'h00040, 1, 3'b000, -1, 2'b0, "R3 single miss data", st);
        chk("R3 single miss stall", 64'(st), 64'd4);
        chk("R3 R1 one array read", 64'(nread - n0), 64'd1);

        // R2 / R5: other half of the same entry
        n0 = nread;
        rd_burst(20'h00044, 1, 3'b000, -1, 2'b0, "R5 upper half data", st);
        chk("R2 hit stall", 64'(st), 64'd0);
        chk("R2 hit no array read", 64'(nread - n0), 64'd0);

        // R4: every wait setting
        for (int k = 0; k < 4; k++) begin
            do_flush();
            fsel = 2'(k);
            rd_burst(20'h00088, 1, 3'b000, -1, 2'b0, "R4 wait data", st);
            chk("R4 stall equals freq+2", 64'(st), 64'(k + 2));
        end

        // R6 / R7: cold wrapping burst starting in entry 1
        fsel = 2'd1; n0 = nread;
        rd_burst(20'h003A8, 8, 3'b100, -1, 2'b0, "R6 wrap8 data", st);
        chk("R7 first beat stall", 64'(st), 64'd3);
        chk("R6 four array reads", 64'(nread - n0), 64'd4);
        for (int i = 0; i < 4; i++)
            chk("R6 fill order", 64'(rlog[(n0 + i) % 16][1:0]), 64'((1 + i) % 4));

        // R8: line replacement
        n0 = nread;
        rd_burst(20'h00500, 1, 3'b000, -1, 2'b0, "R8 other line data", st);
        rd_burst(20'h003A0, 1, 3'b000, -1, 2'b0, "R8 old line data", st);
        chk("R8 both lines refetched", 64'(nread - n0), 64'd2);

        // R9: write invalidates
        n0 = nread;
        rd_burst(20'h003A0, 1, 3'b000, -1, 2'b0, "R9 hit before write", st);
        chk("R9 hit before write no read", 64'(nread - n0), 64'd0);
        wr(20'h00600);
        n0 = nread;
        rd_burst(20'h003A0, 1, 3'b000, -1, 2'b0, "R9 new data after write", st);
        chk("R9 refetch after write", 64'(nread - n0), 64'd1);

        // R10: flush invalidates
        do_flush();
        gen++;
        n0 = nread;
        rd_burst(20'h003A0, 1, 3'b000, -1, 2'b0, "R10 new data after flush", st);
        chk("R10 refetch after flush", 64'(nread - n0), 64'd1);

        // R11: incrementing burst is served as singles
        do_flush();
        n0 = nread;
        rd_burst(20'h00700, 4, 3'b011, -1, 2'b0, "R11 incr4 data", st);
        chk("R11 two entry reads", 64'(nread - n0), 64'd2);

        // R12: freq change mid-read
        do_flush();
        fsel = 2'd3;
        rd_burst(20'h00720, 1, 3'b000, 2, 2'd0, "R12 data with mid-read change", st);
        chk("R12 stall uses sampled freq", 64'(st), 64'd5);

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [14:0] tg;
            logic [AW-1:0] a;
            op   = int'($urandom % 10);
            fsel = 2'($urandom % 4);
            case ($urandom % 4)
                0:       tg = 15'd0;
                1:       tg = 15'd1;
                2:       tg = 15'd5;
                default: tg = 15'h7FFF;
            endcase
            a = {tg, 3'($urandom % 8), 2'b00};
            if (op == 0)      wr(a);
            else if (op == 1) do_flush();
            else if (op < 5)  rd_burst(a, 1, 3'b000, -1, 2'b0, "R5 random single", st);
            else if (op < 8)  rd_burst(a, 8, 3'b100, -1, 2'b0, "R6 random wrap8", st);
            else              rd_burst(a, 4, 3'b011, -1, 2'b0, "R11 random incr4", st);
        end

        report();
    end
endmodule